// File: doc/BRIEF.md
# Per-Bunch FIR Correction Filter with Gain Override

This block turns a stream of bunch-position samples into signed 8-bit kick corrections. Samples arrive interleaved: every sample carries the index of the bunch it belongs to, and a full turn presents each of the N bunches once. For every bunch the block keeps that bunch's own last fifteen samples. A 16-tap FIR runs over the current sample and those fifteen, so the filter only ever mixes samples of one bunch taken on successive turns. The history is held in a memory with one word per bunch. The block reads that word, combines it with the new sample, and writes it back shifted by one tap.

The 36-bit sum is scaled by a gain. The gain is a left shift counted from the top bit of the sum, and the top eight bits of the shifted value are the result. If the shifted value does not fit in signed 8 bits, the result clamps to the nearest limit instead of wrapping. One bunch, chosen by a programmable index, uses its own gain; every other bunch uses the shared gain. Coefficients, gains and the special index are sampled when bunch 0 arrives, so each turn is computed with one consistent set of settings.

Top module: `bunch_fir`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_corr` is 0. Reset also clears the history of every bunch to zero, so the first sample of a bunch after reset is filtered against zeros.
- R2: `out_valid` is high in exactly the cycle after an input cycle with `in_valid` high, and `out_corr` carries that sample's result in the same cycle (one register of latency).
- R3: The sum is the sum over k of c(k)·x(n−k), for k = 0..15. Here x(n−k) is the sample of the same bunch k turns earlier and c(k) is the signed 16-bit field at bits [16k+15:16k] of `coef_flat`. Samples of other bunches never enter a bunch's sum.
- R4: With effective gain g, the result is the 36-bit sum arithmetically shifted right by 28−g. This equals the top eight bits of the sum shifted left by g.
- R5: If that shifted value is above 127 the output is 127 (0x7F). If it is below −128 the output is −128 (0x80).
- R6: A gain code above 27 acts as 27.
- R7: The bunch whose index equals `one_bunch` uses `gain_one`. All other bunches use `gain_all`.
- R8: Coefficients, both gains and `one_bunch` are captured in the cycle where `in_valid` is high with `in_bunch` = 0, and that cycle already uses the new values. Changes made at any other time have no effect until the next such cycle.
- R9: Cycles with `in_valid` low leave every bunch's history unchanged and hold `out_corr` at its last value.
- R10: The full coefficient and sample range is supported, including −32768·−32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_bunch | input | $clog2(N) | Bunch index of the sample |
| in_sample | input | 16 | Signed sample |
| coef_flat | input | 256 | Sixteen signed 16-bit coefficients, tap k at [16k+15:16k] |
| gain_all | input | 5 | Shared gain, 0..27 |
| gain_one | input | 5 | Gain for the selected bunch |
| one_bunch | input | $clog2(N) | Index of the bunch using `gain_one` |
| out_valid | output | 1 | Correction present |
| out_corr | output | 8 | Signed saturated correction |

## Verification
The assertions assume that `in_bunch` stays below N. They also assume that settings are treated as live wires that may change in any cycle, since only the bunch-0 capture is checked. The stimulus sends bunches in order 0..N−1 with a small N, so every turn begins with bunch 0. It changes the gain partway through a turn on purpose, to exercise the deferred capture. Idle gaps are inserted only between samples and never reorder bunches, so the per-bunch turn history the reference model keeps stays aligned with the design's.

// File: rtl/bunch_fir.sv
module bunch_fir #(
  parameter int N    = 480,
  parameter int TAPS = 16,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 36,
  parameter int OW   = 8,
  parameter int GW   = 5,
  parameter int GMAX = 27
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [$clog2(N)-1:0]   in_bunch,
  input  logic [DW-1:0]          in_sample,
  input  logic [TAPS*CW-1:0]     coef_flat,
  input  logic [GW-1:0]          gain_all,
  input  logic [GW-1:0]          gain_one,
  input  logic [$clog2(N)-1:0]   one_bunch,
  output logic                   out_valid,
  output logic [OW-1:0]          out_corr
);
  localparam int BW = $clog2(N);
  localparam int HW = (TAPS-1)*DW;
  localparam int PW = DW+CW;
  localparam int SHB = AW-OW;

  logic [HW-1:0]      hist [N];
  logic [TAPS*CW-1:0] act_coef;
  logic [GW-1:0]      act_gall, act_gone;
  logic [BW-1:0]      act_one;

  logic               load, in_rng;
  logic [TAPS*CW-1:0] eff_coef;
  logic [GW-1:0]      eff_gall, eff_gone, gsel, gcl;
  logic [BW-1:0]      eff_one;
  logic [HW-1:0]      rd;
  logic [TAPS*DW-1:0] taps;
  logic signed [AW-1:0] acc, sh;
  logic               fits;
  logic [OW-1:0]      sat;

  assign load     = in_valid && (in_bunch == '0);
  assign in_rng   = {1'b0, in_bunch} < (BW+1)'(N);
  assign eff_coef = load ? coef_flat : act_coef;
  assign eff_gall = load ? gain_all  : act_gall;
  assign eff_gone = load ? gain_one  : act_gone;
  assign eff_one  = load ? one_bunch : act_one;

  assign rd   = in_rng ? hist[in_bunch] : '0;
  assign taps = {rd, in_sample};

  always_comb begin
    logic signed [PW-1:0] p;
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      p   = $signed(taps[k*DW +: DW]) * $signed(eff_coef[k*CW +: CW]);
      acc = acc + AW'(p);
    end
  end

  assign gsel = (in_bunch == eff_one) ? eff_gone : eff_gall;
  assign gcl  = (gsel > GW'(GMAX)) ? GW'(GMAX) : gsel;
  assign sh   = acc >>> (SHB - 32'(gcl));
  assign fits = (sh[AW-1:OW-1] == '0) || (&sh[AW-1:OW-1]);
  assign sat  = fits ? sh[OW-1:0] :
                (sh[AW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) hist[i] <= '0;
      act_coef  <= '0;
      act_gall  <= '0;
      act_gone  <= '0;
      act_one   <= '0;
      out_valid <= 1'b0;
      out_corr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (load) begin
        act_coef <= coef_flat;
        act_gall <= gain_all;
        act_gone <= gain_one;
        act_one  <= one_bunch;
      end
      if (in_valid) begin
        out_corr <= sat;
        if (in_rng) hist[in_bunch] <= taps[HW-1:0];
      end
    end
  end
endmodule

// File: rtl/bunch_fir_chk.sv
module bunch_fir_chk #(
  parameter int BW = 9,
  parameter int GW = 5,
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [BW-1:0] in_bunch,
  input logic          out_valid,
  input logic [OW-1:0] out_corr,
  input logic [GW-1:0] act_gall,
  input logic [GW-1:0] act_gone,
  input logic [BW-1:0] act_one
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_corr == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_corr));

  a_r8_turn_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_bunch == '0) |=> ($stable(act_gall) && $stable(act_gone) && $stable(act_one)));
endmodule

bind bunch_fir bunch_fir_chk #(.BW(BW), .GW(GW), .OW(OW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bunch(in_bunch),
  .out_valid(out_valid), .out_corr(out_corr),
  .act_gall(act_gall), .act_gone(act_gone), .act_one(act_one)
);

// File: tb/bunch_fir_test.sv
module bunch_fir_test;
  localparam int N  = 4;
  localparam int BW = $clog2(N);

  logic clk = 0;
  always #5 clk = ~clk;

  logic                rst_n, in_valid;
  logic [BW-1:0]       in_bunch, one_bunch;
  logic [15:0]         in_sample;
  logic [255:0]        coef_flat;
  logic [4:0]          gain_all, gain_one;
  logic                out_valid;
  logic [7:0]          out_corr;

  bunch_fir #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bunch(in_bunch),
    .in_sample(in_sample), .coef_flat(coef_flat), .gain_all(gain_all),
    .gain_one(gain_one), .one_bunch(one_bunch), .out_valid(out_valid),
    .out_corr(out_corr)
  );

  int vecs = 0, errs = 0;

  longint m_hist [N][15];
  logic [255:0] m_coef;
  int m_ga, m_go, m_ob;

  localparam logic [15:0] STIM [0:23] = '{
    16'd120, 16'hFF38, 16'd45, 16'd300, 16'hFE0C, 16'd7, 16'd999, 16'hFFFF,
    16'd64, 16'd512, 16'hF830, 16'd3, 16'h7FFF, 16'd0, 16'd250, 16'hFF9C,
    16'd17, 16'hFC18, 16'd640, 16'd88, 16'h8000, 16'd222, 16'hFFF0, 16'd1000
  };

  task automatic model_reset();
    for (int b = 0; b < N; b++) for (int k = 0; k < 15; k++) m_hist[b][k] = 0;
    m_coef = '0; m_ga = 0; m_go = 0; m_ob = 0;
  endtask

  function automatic int model_out(int b, longint x0);
    longint acc, v;
    int g;
    acc = longint'($signed(m_coef[15:0])) * x0;
    for (int k = 1; k < 16; k++)
      acc += longint'($signed(m_coef[k*16 +: 16])) * m_hist[b][k-1];
    g = (b == m_ob) ? m_go : m_ga;
    if (g > 27) g = 27;
    v = acc >>> (28 - g);
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return int'(v);
  endfunction

  task automatic check(string tag, logic ok, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one sample at a falling edge; compare at the next falling edge
  task automatic step(int b, logic [15:0] s, string tag, bit hand, int hexp);
    int e;
    longint x0;
    in_valid = 1; in_bunch = BW'(b); in_sample = s;
    if (b == 0) begin
      m_coef = coef_flat; m_ga = gain_all; m_go = gain_one; m_ob = one_bunch;
    end
    x0 = longint'($signed(s));
    e = hand ? hexp : model_out(b, x0);
    for (int k = 14; k > 0; k--) m_hist[b][k] = m_hist[b][k-1];
    m_hist[b][0] = x0;
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid"}, out_valid === 1'b1, int'(out_valid), 1);
    check(tag, $signed(out_corr) == e, int'($signed(out_corr)), e);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    @(negedge clk); @(negedge clk);
    check("R1 reset valid", out_valid === 1'b0, int'(out_valid), 0);
    check("R1 reset corr", out_corr === 8'd0, int'(out_corr), 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic set_single(logic [15:0] c0, logic [4:0] g);
    coef_flat = '0; coef_flat[15:0] = c0; gain_all = g; gain_one = g; one_bunch = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    in_bunch = 0; in_sample = 0; coef_flat = '0;
    gain_all = 0; gain_one = 0; one_bunch = 0; in_valid = 0;
    @(negedge clk);
    do_reset();

    // R3 R4 R7: interleaved table with mixed coefficients, special bunch 2
    for (int k = 0; k < 16; k++) coef_flat[k*16 +: 16] = 16'(300 - 45*k);
    gain_all = 12; gain_one = 16; one_bunch = 2;
    for (int i = 0; i < 24; i++) step(i % N, STIM[i], "R3/R7 table", 0, 0);

    // R9: idle gap keeps output and history
    begin
      logic [7:0] held;
      held = out_corr;
      repeat (3) @(negedge clk);
      check("R9 idle valid", out_valid === 1'b0, int'(out_valid), 0);
      check("R9 idle hold", out_corr === held, int'(out_corr), int'(held));
    end
    for (int i = 0; i < 8; i++) step(i % N, STIM[23-i], "R9 history kept", 0, 0);

    // R8: change settings mid-turn; only the next bunch 0 picks them up
    for (int t = 0; t < 3; t++)
      for (int b = 0; b < N; b++) begin
        if (b == 2) begin
          gain_all = 5'(8 + 6*t); gain_one = 5'(20 - t); one_bunch = BW'(t + 1);
          coef_flat[15:0] = 16'(1000*t - 700);
        end
        step(b, 16'(b*77 - 150 + t*40), "R8 turn capture", 0, 0);
      end

    // R1: history cleared; all coefs 1, shift 8 -> 256/256 = 1
    do_reset();
    for (int k = 0; k < 16; k++) coef_flat[k*16 +: 16] = 16'd1;
    gain_all = 20; gain_one = 20; one_bunch = 0;
    step(0, 16'd256, "R1 history zero", 1, 1);

    // R4: gain 27 halves, gain 20 divides by 256
    do_reset();
    set_single(16'd1, 5'd27);
    step(0, 16'd100, "R4 gain 27", 1, 50);
    set_single(16'd1, 5'd20);
    step(0, 16'd25600, "R4 gain 20", 1, 100);

    // R6: gain code 31 acts as 27
    do_reset();
    set_single(16'd1, 5'd31);
    step(0, 16'd100, "R6 gain clamp", 1, 50);

    // R5: saturation both ways
    do_reset();
    set_single(16'h7FFF, 5'd27);
    step(0, 16'h7FFF, "R5 clamp high", 1, 127);
    do_reset();
    set_single(16'h7FFF, 5'd27);
    step(0, 16'h8000, "R5 clamp low", 1, -128);

    // R10: -32768 * -32768 = 2^30, gain 0 -> 2^30 >>> 28 = 4
    do_reset();
    set_single(16'h8000, 5'd0);
    step(0, 16'h8000, "R10 extreme product", 1, 4);

    // R7: special bunch 1 uses its own gain; others shared
    do_reset();
    coef_flat = '0; coef_flat[15:0] = 16'd1;
    gain_all = 20; gain_one = 27; one_bunch = 1;
    step(0, 16'd2560, "R7 shared gain", 1, 10);
    step(1, 16'd40, "R7 special gain", 1, 20);
    step(2, 16'd2560, "R7 shared gain", 1, 10);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule